// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for a synchronous memory array during short bursts. A base address is captured from the address bus when either of two active-low strobes requests a load. One strobe is meant for a processor and the other for a cache or memory controller. The upper address bits are then held unchanged. The two lowest bits step through a four-beat sequence, one beat on each clock in which the active-low advance input is asserted.

The order of the beats is chosen by a mode input. In linear order the start offset is incremented modulo four. In interleaved order the start offset is XORed with a beat count that runs 0, 1, 2, 3. In both orders the fourth advance brings the low bits back to the start offset. Loads may be issued on every cycle, so a user that never advances gets plain single-word addressing. The processor strobe only counts when the chip-enable flag (active low) is asserted. The controller strobe loads no matter what that flag holds.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `word_addr` is all zeros.
- R2: A clock edge with `ctl_ld_n` low loads `addr_in`, whatever the value of `ce_n`. `word_addr` equals that address from the next cycle on.
- R3: A clock edge with `cpu_ld_n` low and `ce_n` low loads `addr_in` in the same way.
- R4: A clock edge with `cpu_ld_n` low, `ce_n` high and `ctl_ld_n` high loads nothing. No bit of `word_addr` changes on that edge unless `adv_n` is low.
- R5: A clock edge with no load and `adv_n` high leaves `word_addr` unchanged.
- R6: When `ilv_order` is 0 (linear), `word_addr[1:0]` after k advances since the last load equals (start + k) mod 4.
- R7: When `ilv_order` is 1 (interleaved), `word_addr[1:0]` after k advances equals start XOR (k mod 4).
- R8: The fourth advance after a load returns `word_addr[1:0]` to the start offset. This holds in both orders.
- R9: A load on the same edge as `adv_n` low takes priority. The new address appears with beat count zero.
- R10: Advances never carry into or alter `word_addr[ADDR_W-1:2]`.
- R11: Loads on consecutive cycles each take effect one cycle later, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External address to load |
| cpu_ld_n | input | 1 | Processor load strobe, active low, qualified by `ce_n` |
| ctl_ld_n | input | 1 | Controller load strobe, active low, unqualified |
| ce_n | input | 1 | Chip-enable flag, active low |
| adv_n | input | 1 | Advance one beat, active low |
| ilv_order | input | 1 | Beat order: 0 linear, 1 interleaved |
| word_addr | output | ADDR_W | Current word address to the array |

## Verification
Two functions can fall in the same cycle: a load from either strobe and a beat advance. This happens when a strobe and `adv_n` are both low on one edge. A second case is a processor strobe that is refused because `ce_n` is high while `adv_n` is asserted. The bench provokes both with random strobe, enable and advance patterns, plus directed sequences that overlap them. It judges each cycle against a bench model in which a load clears the beat count and wins over the advance, and a refused processor strobe leaves the advance to act alone.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_CPU  = 2'd1,
        LD_CTL  = 2'd2
    } ld_src_e;

endpackage

// File: rtl/burst_ld_arb.sv
module burst_ld_arb
    import burst_addr_pkg::*;
(
    input  logic    cpu_ld_n,
    input  logic    ctl_ld_n,
    input  logic    ce_n,
    output ld_src_e ld_src,
    output logic    ld_any
);
    always_comb begin
        ld_src = LD_NONE;
        if (!ctl_ld_n) begin
            ld_src = LD_CTL;
        end else if (!cpu_ld_n && !ce_n) begin
            ld_src = LD_CPU;
        end
        ld_any = (ld_src != LD_NONE);
    end

    always_comb begin
        if (!ctl_ld_n) begin
            a_r2_ctl_wins: assert (ld_any);
        end
        if (ctl_ld_n && ce_n) begin
            a_r4_cpu_gated: assert (!ld_any);
        end
    end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_any,
    input  logic             adv_n,
    output logic [OFS_W-1:0] beat
);
    typedef struct packed {
        logic [OFS_W-1:0] beat;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_any) begin
            st_d.beat = '0;
        end else if (!adv_n) begin
            st_d.beat = st_q.beat + OFS_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat = st_q.beat;

    a_r9_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ld_any |=> beat == '0);
    a_r5_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_any && adv_n) |=> beat == $past(beat));
    a_r6_step_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_any && !adv_n) |=> beat == $past(beat) + OFS_W'(1));
endmodule

// File: rtl/burst_ofs_map.sv
module burst_ofs_map #(
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] start,
    input  logic [OFS_W-1:0] beat,
    input  logic             ilv_order,
    output logic [OFS_W-1:0] ofs
);
    logic [OFS_W-1:0] lin_ofs;
    logic [OFS_W-1:0] xor_ofs;

    assign lin_ofs = start + beat;

    for (genvar i = 0; i < OFS_W; i++) begin : g_xor
        assign xor_ofs[i] = start[i] ^ beat[i];
    end

    assign ofs = ilv_order ? xor_ofs : lin_ofs;

    always_comb begin
        if (beat == '0) begin
            a_r8_zero_beat_is_start: assert (ofs == start);
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cpu_ld_n,
    input  logic              ctl_ld_n,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic              ilv_order,
    output logic [ADDR_W-1:0] word_addr
);
    localparam int HI_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [OFS_W-1:0] start;
    } base_t;

    base_t            st_d, st_q;
    ld_src_e          ld_src;
    logic             ld_any;
    logic [OFS_W-1:0] beat;
    logic [OFS_W-1:0] ofs;

    burst_ld_arb u_arb (
        .cpu_ld_n (cpu_ld_n),
        .ctl_ld_n (ctl_ld_n),
        .ce_n     (ce_n),
        .ld_src   (ld_src),
        .ld_any   (ld_any)
    );

    burst_beat_cnt #(.OFS_W(OFS_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_any (ld_any),
        .adv_n  (adv_n),
        .beat   (beat)
    );

    always_comb begin
        st_d = st_q;
        if (ld_any) begin
            st_d.hi    = addr_in[ADDR_W-1:OFS_W];
            st_d.start = addr_in[OFS_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    burst_ofs_map #(.OFS_W(OFS_W)) u_map (
        .start     (st_q.start),
        .beat      (beat),
        .ilv_order (ilv_order),
        .ofs       (ofs)
    );

    assign word_addr = {st_q.hi, ofs};

    a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_ld_n |=> word_addr == $past(addr_in));
    a_r3_cpu_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ld_n && !ce_n) |=> word_addr == $past(addr_in));
    a_r4_cpu_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_src == LD_NONE) |=> st_q == $past(st_q));
    a_r10_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_any |=> word_addr[ADDR_W-1:OFS_W] == $past(word_addr[ADDR_W-1:OFS_W]));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          cpu_ld_n = 1'b1;
    logic          ctl_ld_n = 1'b1;
    logic          ce_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          ilv_order = 1'b0;
    logic [AW-1:0] word_addr;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;

    always #4 clk = ~clk;

    burst_addr_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_in   (addr_in),
        .cpu_ld_n  (cpu_ld_n),
        .ctl_ld_n  (ctl_ld_n),
        .ce_n      (ce_n),
        .adv_n     (adv_n),
        .ilv_order (ilv_order),
        .word_addr (word_addr)
    );

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] k, logic ilv);
        logic [1:0] lo;
        lo = ilv ? (b[1:0] ^ k) : (b[1:0] + k);
        return {b[AW-1:2], lo};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_base = '0;
            m_beat = '0;
        end else if (!ctl_ld_n || (!cpu_ld_n && !ce_n)) begin
            m_base = addr_in;
            m_beat = '0;
        end else if (!adv_n) begin
            m_beat = m_beat + 2'd1;
        end
    end

    task automatic check(string tag, logic [AW-1:0] exp);
        checks++;
        if (word_addr !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, word_addr, exp);
        end
    endtask

    task automatic cyc(string tag, logic [AW-1:0] a, logic cp, logic ct,
                       logic ce, logic adv, logic ilv);
        addr_in = a; cpu_ld_n = cp; ctl_ld_n = ct; ce_n = ce; adv_n = adv; ilv_order = ilv;
        @(negedge clk);
        check(tag, exp_addr(m_base, m_beat, ilv_order));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", '0);

        // R2: controller strobe loads with enable high
        cyc("R2", 18'h2ABC6, 1, 0, 1, 1, 0);
        check("R2", 18'h2ABC6);
        // R6: linear from start 10 -> 11,00,01, then R8 wraps to 10
        cyc("R6", 18'h0, 1, 1, 1, 0, 0);
        check("R6", 18'h2ABC7);
        cyc("R6", 18'h0, 1, 1, 1, 0, 0);
        check("R10", 18'h2ABC4);
        cyc("R6", 18'h0, 1, 1, 1, 0, 0);
        cyc("R8", 18'h0, 1, 1, 1, 0, 0);
        check("R8", 18'h2ABC6);
        // R5: hold
        cyc("R5", 18'h11111, 1, 1, 0, 1, 0);
        check("R5", 18'h2ABC6);
        // R3: cpu strobe with enable low, interleaved from start 11
        cyc("R3", 18'h01237, 0, 1, 0, 1, 1);
        check("R3", 18'h01237);
        cyc("R7", 18'h0, 1, 1, 1, 0, 1);
        check("R7", 18'h01236);
        cyc("R7", 18'h0, 1, 1, 1, 0, 1);
        check("R7", 18'h01235);
        cyc("R7", 18'h0, 1, 1, 1, 0, 1);
        check("R7", 18'h01234);
        cyc("R8", 18'h0, 1, 1, 1, 0, 1);
        check("R8", 18'h01237);
        // R4: refused cpu strobe, no advance
        cyc("R4", 18'h3FFFC, 0, 1, 1, 1, 1);
        check("R4", 18'h01237);
        // R4 with advance: advance acts alone
        cyc("R4", 18'h3FFFC, 0, 1, 1, 0, 1);
        check("R4", 18'h01236);
        // R9: load and advance together
        cyc("R9", 18'h15555, 1, 0, 1, 0, 0);
        check("R9", 18'h15555);
        // R11: back-to-back loads
        cyc("R11", 18'h00002, 0, 1, 0, 0, 0);
        check("R11", 18'h00002);
        cyc("R11", 18'h3000F, 1, 0, 0, 1, 1);
        check("R11", 18'h3000F);
        cyc("R11", 18'h12345, 0, 0, 1, 0, 0);
        check("R11", 18'h12345);

        for (int i = 0; i < 3000; i++) begin
            logic cp, ct, ce, adv, ilv;
            string tag;
            cp  = ($urandom % 4) != 0;
            ct  = ($urandom % 5) != 0;
            ce  = $urandom % 2;
            adv = $urandom % 2;
            ilv = (i / 200) % 2;
            if (!ct) tag = "R2";
            else if (!cp && !ce) tag = "R3";
            else if (!cp) tag = "R4";
            else if (!adv) tag = ilv ? "R7" : "R6";
            else tag = "R5";
            cyc(tag, AW'($urandom), cp, ct, ce, adv, ilv);
        end
        done = 1'b1;
    end

    initial begin
        wait (done || cycles > 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule